// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag and Enable Unit

This block keeps the interrupt state of a PC-style real-time clock. Three one-cycle event pulses arrive from elsewhere in the clock: a periodic tick, an alarm match and an end-of-update. Each pulse sets its own sticky flag, even when that event's interrupt is disabled. A control register holds one enable per event. The enable sits at the same bit position as its flag, so the flags can be masked against the enables with no reordering.

A summary bit reports that at least one enabled flag is pending, and an active-high, level-sensitive request line follows that summary. Software reaches both registers through a small synchronous read/write port. Reading the status register returns the flags and the summary, and clears all flags in the same access. An event that arrives in the cycle of that read is kept for the next read.

Top module: `rtc_irq_unit`

## Requirements
- R1: A synchronous active-low reset clears all enables and all flags. After reset, `irq` is low and both registers read 0x00.
- R2: A write to the control address (0xB) loads the enables from data bits 6 (periodic), 5 (alarm) and 4 (update). A read of that address returns the enables in those bits, and every other bit reads 0.
- R3: A pulse on an event input sets its flag at the next clock edge, whatever its enable holds. In the status register the periodic flag is bit 6, alarm is bit 5 and update is bit 4. A set flag stays set until the status register is read.
- R4: Status bit 7 is 1 exactly when some flag and its matching enable are both set. Status bits 3:0 always read 0.
- R5: `irq` is active-high and level-sensitive. It equals status bit 7, and it stays high across idle cycles until the status register is read or the enables change.
- R6: A read of the status address (0xC) returns the current flags and summary. The same access clears all flags, so `irq` is low in the next cycle if no event arrives with the read.
- R7: An event that arrives in the same cycle as a status read is not part of that read's value. Its flag is set after the read.
- R8: Writing zero to all enables drops `irq` in the next cycle. The raw flags stay latched and are still readable with bit 7 at 0.
- R9: Setting an enable for a flag that is already pending raises `irq` in the cycle after the write.
- R10: A write to any address other than the control address changes no state. A read of any address other than control or status returns 0x00 and clears no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W (4) | Register address |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle; a status read clears the flags |
| wdata | input | DATA_W (8) | Write data |
| rdata | output | DATA_W (8) | Read data, valid in the cycle of `rd_en` |
| ev_periodic | input | 1 | Periodic tick event pulse |
| ev_alarm | input | 1 | Alarm match event pulse |
| ev_update | input | 1 | End-of-update event pulse |
| irq | output | 1 | Active-high level interrupt request |

## Verification
The bench builds the block with its default parameters. These are a 4-bit address with control at 0xB and status at 0xC, the event field starting at bit 4 and the summary at bit 7. That layout is what puts the encodings in R2 to R4 directly in reach of the expected read values. With this layout the bench can cover each event alone and all three together, an event landing on the read cycle, enables dropped while flags stay pending, and an enable raised over a flag that is already latched.

// File: rtl/rtc_irq_pkg.sv
// Shared definitions for the RTC interrupt unit.
// Assumes three event sources, numbered so that index i lands at bit EVT_LSB+i.
package rtc_irq_pkg;
    localparam int NUM_EVT = 3;
    localparam int EV_UPD  = 0;
    localparam int EV_ALM  = 1;
    localparam int EV_PER  = 2;

    // Decoded register access for one cycle
    typedef struct packed {
        logic ctrl_wr;
        logic ctrl_rd;
        logic stat_rd;
    } rtc_acc_t;
endpackage

// File: rtl/rtc_irq_decode.sv
// Address decoder: turns strobes and address into per-register access bits.
// Assumes the control and status addresses differ.
module rtc_irq_decode
    import rtc_irq_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 11,
    parameter int STAT_ADDR = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output rtc_acc_t          acc
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

    // Match the address against both registers
    always_comb begin
        acc.ctrl_wr = wr_en && (addr == CTRL_A);
        acc.ctrl_rd = rd_en && (addr == CTRL_A);
        acc.stat_rd = rd_en && (addr == STAT_A);
    end
endmodule

// File: rtl/rtc_irq_enables.sv
// Enable register: holds one interrupt enable per event.
// Assumes the load strobe is already decoded.
module rtc_irq_enables #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [N-1:0] din,
    output logic [N-1:0] en_q
);
    // Load the enables on a control write, and clear them on reset
    always_ff @(posedge clk) begin
        if (!rst_n)  en_q <= '0;
        else if (ld) en_q <= din;
    end

    p_enable_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(en_q));
    p_enable_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (en_q == $past(din)));
endmodule

// File: rtl/rtc_irq_flag_cell.sv
// Sticky event flag: an event sets it, a status read clears it.
// Assumes evt is a one-cycle pulse. A set on the same edge as a clear wins.
module rtc_irq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic flag_q
);
    // Set has priority over clear, so no event is lost on a read cycle
    always_ff @(posedge clk) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (evt) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    // R3 and R7: an event always leaves the flag set, read or not
    p_event_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag_q);
    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);
    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> !flag_q);
endmodule

// File: rtl/rtc_irq_unit.sv
// RTC interrupt flag and enable unit (top).
// Latches three event pulses into flags and masks them with the enables.
// Drives a summary bit and a level interrupt. A status read clears the flags.
// Assumes EVT_LSB + NUM_EVT <= IRQF_BIT < DATA_W.
module rtc_irq_unit
    import rtc_irq_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int CTRL_ADDR = 11,
    parameter int STAT_ADDR = 12,
    parameter int EVT_LSB   = 4,
    parameter int IRQF_BIT  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ev_periodic,
    input  logic              ev_alarm,
    input  logic              ev_update,
    output logic              irq
);
    localparam int EVT_HI = EVT_LSB + NUM_EVT - 1;

    rtc_acc_t           acc;
    logic [NUM_EVT-1:0] ev_vec;
    logic [NUM_EVT-1:0] en_q;
    logic [NUM_EVT-1:0] flag_q;
    logic               irqf;
    logic               wdata_unused;

    // Gather the event pulses in bit order
    always_comb begin
        ev_vec         = '0;
        ev_vec[EV_UPD] = ev_update;
        ev_vec[EV_ALM] = ev_alarm;
        ev_vec[EV_PER] = ev_periodic;
    end

    // Only the event field of the write data is stored
    assign wdata_unused = ^{wdata[DATA_W-1:EVT_HI+1], wdata[EVT_LSB-1:0]};

    rtc_irq_decode #(
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR),
        .STAT_ADDR(STAT_ADDR)
    ) u_decode (
        .addr (addr),
        .wr_en(wr_en),
        .rd_en(rd_en),
        .acc  (acc)
    );

    rtc_irq_enables #(.N(NUM_EVT)) u_enables (
        .clk  (clk),
        .rst_n(rst_n),
        .ld   (acc.ctrl_wr),
        .din  (wdata[EVT_HI:EVT_LSB]),
        .en_q (en_q)
    );

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
        rtc_irq_flag_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (ev_vec[i]),
            .clr   (acc.stat_rd),
            .flag_q(flag_q[i])
        );
    end

    // Summary: any flag whose enable shares its bit position
    assign irqf = |(flag_q & en_q);
    assign irq  = irqf;

    // Read mux: control shows the enables, status shows the flags plus the summary
    always_comb begin
        rdata = '0;
        if (acc.ctrl_rd) begin
            rdata[EVT_HI:EVT_LSB] = en_q;
        end else if (acc.stat_rd) begin
            rdata[EVT_HI:EVT_LSB] = flag_q;
            rdata[IRQF_BIT]       = irqf;
        end
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0 && flag_q == '0 && !irq));
    p_no_enable_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);
    p_irq_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !acc.stat_rd && !acc.ctrl_wr) |=> irq);
    p_read_drops_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.stat_rd && ev_vec == '0) |=> !irq);
    p_other_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !acc.ctrl_wr) |=> $stable(en_q));
endmodule

// File: tb/rtc_irq_unit_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue the expected read data, and a monitor compares it.
module rtc_irq_unit_tb;
    localparam logic [3:0] A_CTRL = 4'hB;
    localparam logic [3:0] A_STAT = 4'hC;
    localparam logic [3:0] A_IDLE = 4'h0;
    localparam logic [2:0] E_PER = 3'b100, E_ALM = 3'b010, E_UPD = 3'b001;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] ev = '0;
    logic       irq;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] m_exp;
    string      m_tag;

    always #2.5 clk = ~clk;

    rtc_irq_unit #(
        .ADDR_W(4), .DATA_W(8), .CTRL_ADDR(11), .STAT_ADDR(12),
        .EVT_LSB(4), .IRQF_BIT(7)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .ev_periodic(ev[2]), .ev_alarm(ev[1]),
        .ev_update(ev[0]), .irq(irq)
    );

    task automatic drive(input logic [3:0] a, input logic w, input logic r,
                         input logic [7:0] d, input logic [2:0] e);
        @(posedge clk);
        #1;
        addr = a; wr_en = w; rd_en = r; wdata = d; ev = e;
    endtask

    task automatic idle();
        drive(A_IDLE, 1'b0, 1'b0, 8'h00, 3'b000);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        drive(a, 1'b1, 1'b0, d, 3'b000);
    endtask

    task automatic pulse(input logic [2:0] e);
        drive(A_IDLE, 1'b0, 1'b0, 8'h00, e);
    endtask

    task automatic rd_ev(input logic [3:0] a, input logic [2:0] e,
                         input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        drive(a, 1'b0, 1'b1, 8'h00, e);
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        rd_ev(a, 3'b000, exp, tag);
    endtask

    task automatic check_irq(input logic exp, input string tag);
        @(negedge clk);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s: irq actual=%b expected=%b", tag, irq, exp);
        end
    endtask

    // Monitor: pop the expected value for every read cycle and compare
    always @(negedge clk) begin
        if (rst_n && rd_en) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: rdata actual=%02h expected=<none>", rdata);
            end else begin
                m_exp = exp_q.pop_front();
                m_tag = tag_q.pop_front();
                if (rdata !== m_exp) begin
                    errors++;
                    $display("FAIL %s: rdata actual=%02h expected=%02h", m_tag, rdata, m_exp);
                end
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        idle();
        rd(A_CTRL, 8'h00, "R1 control after reset");
        rd(A_STAT, 8'h00, "R1 status after reset");
        idle();
        check_irq(1'b0, "R1 irq after reset");

        pulse(E_PER); idle();
        check_irq(1'b0, "R3 disabled flag raises no irq");
        rd(A_STAT, 8'h40, "R3 periodic flag latched while disabled");
        rd(A_STAT, 8'h00, "R6 flags cleared by read");
        pulse(E_PER | E_ALM | E_UPD); idle();
        rd(A_STAT, 8'h70, "R4 all flags, summary low with no enables");

        wr(A_CTRL, 8'hFF);
        rd(A_CTRL, 8'h70, "R2 control keeps only enable bits");
        wr(A_CTRL, 8'h20);
        rd(A_CTRL, 8'h20, "R2 alarm enable alone");

        pulse(E_ALM); idle();
        check_irq(1'b1, "R5 irq on enabled alarm");
        idle(); idle(); idle();
        check_irq(1'b1, "R5 irq held while idle");
        rd(A_STAT, 8'hA0, "R4 summary with alarm flag");
        idle();
        check_irq(1'b0, "R6 irq drops after status read");

        pulse(E_UPD); idle();
        check_irq(1'b0, "R4 update flag not enabled");
        rd(A_STAT, 8'h10, "R3 update flag position");

        pulse(E_ALM); idle();
        check_irq(1'b1, "R8 irq before enables cleared");
        wr(A_CTRL, 8'h00); idle();
        check_irq(1'b0, "R8 irq drops with enables cleared");
        rd(A_STAT, 8'h20, "R8 flag still latched, summary low");

        pulse(E_PER); idle();
        check_irq(1'b0, "R9 pending flag before enable");
        wr(A_CTRL, 8'h40); idle();
        check_irq(1'b1, "R9 enable over pending flag");
        rd(A_STAT, 8'hC0, "R9 status after late enable");

        rd_ev(A_STAT, E_ALM, 8'h00, "R7 same-cycle event not in read value");
        rd(A_STAT, 8'h20, "R7 same-cycle event kept");
        pulse(E_PER); idle();
        rd_ev(A_STAT, E_PER, 8'hC0, "R7 read with repeat periodic event");
        idle();
        check_irq(1'b1, "R7 irq kept by same-cycle event");
        rd(A_STAT, 8'hC0, "R7 flag re-latched");
        idle();
        check_irq(1'b0, "R6 irq clear after final read");

        pulse(E_UPD);
        wr(A_STAT, 8'hFF);
        rd(4'h3, 8'h00, "R10 unmapped read returns zero");
        rd(A_CTRL, 8'h40, "R10 status write left enables");
        rd(A_STAT, 8'h10, "R10 unmapped read cleared no flag");
        idle(); idle();
        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    checks++; errors++;
                    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
                end
            end
        join_any
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: %0d reads not seen, expected 0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule